// File: doc/BRIEF.md
# Descriptor Ring Source Engine

This block is the device side of a transmit descriptor ring. Software builds descriptors in memory. It sets the ring base, the entry count and a transfer length cap through a small register port. It then publishes new work by moving the write index. Whenever its own read index trails the write index, the engine fetches the next descriptor over a single-outstanding memory request/response port. It then reads the referenced buffer one 32-bit word at a time and sends each word out on a valid/ready stream, together with a byte-enable mask, an end-of-transfer marker and the descriptor's transfer tag.

A descriptor takes two words. The first word holds the buffer address. The second word holds the byte count in its low half and the flags in its high half. A chain flag lets several descriptors form one outbound transfer, so only the final descriptor raises the end marker. A reverse flag reverses the byte order of every payload word. The read index moves by one after the final beat of a descriptor has been accepted downstream. Software polls it to retire entries. The engine never fetches the slot the write index points at, so software keeps one entry free to tell a full ring from an empty one.

The control sequence is one state machine. Its states are `ST_IDLE`, `ST_DADDR_REQ`, `ST_DADDR_WAIT`, `ST_DCNT_REQ`, `ST_DCNT_WAIT`, `ST_BUF_REQ`, `ST_BUF_WAIT` and `ST_EMIT`. It moves through them as follows:
- `ST_IDLE` goes to `ST_DADDR_REQ` when the ring is enabled and the read index differs from the write index.
- Each `*_REQ` state goes to its `*_WAIT` state when the request is accepted.
- `ST_DADDR_WAIT` goes to `ST_DCNT_REQ` on the response, `ST_DCNT_WAIT` goes to `ST_BUF_REQ`, and `ST_BUF_WAIT` goes to `ST_EMIT`.
- `ST_EMIT` goes back to `ST_BUF_REQ` when a non-final beat is accepted, and to `ST_IDLE` when the final beat is accepted.

Top module: `dring_src_engine`

## Requirements
- R1: After reset every register reads zero, and `out_valid` and `mem_req_valid` are low.
- R2: The register offsets are: 0 ring base, 1 entry count, 2 write index, 3 read index (read-only), 4 length cap (bits 15:0), 5 status (bit 0 is the sticky clip flag). A write to the write index is masked with count-1. Writing the entry count clears both indices. A write to offset 3 has no effect.
- R3: With an entry count of zero, or with the read index equal to the write index, the engine issues no memory request.
- R4: The descriptor at index i is read from base+8*i. Word 0 is the buffer address. Word 1 bits 15:0 are the byte count and bits 31:16 are the flags: bit 16 chain, bit 17 reverse, bits 31:18 transfer tag.
- R5: A descriptor of effective length L sends ceil(L/4) beats in little-endian byte order, read from consecutive words. Each beat's `out_keep` marks its valid low bytes. A length of zero sends one beat with `out_keep` = 0.
- R6: `out_last` is high only on the final beat of a descriptor whose chain flag is clear, so a chain yields exactly one end marker.
- R7: The read index advances by one, modulo the entry count, only after the final beat of a descriptor is accepted.
- R8: A byte count above the length cap is cut to the cap and sets the status flag. A count equal to the cap sets nothing. Writing 1 to status bit 0 clears the flag, and it otherwise holds.
- R9: With the reverse flag set, the four bytes of each payload word leave in reverse order.
- R10: A pending memory request keeps its address, and a stalled output beat keeps its data, until each is accepted.
- R11: In the middle of a chain, when no further descriptor has been published, the engine consumes what it has, then waits without sending an end marker.
- R12: `out_id` carries the transfer tag of the descriptor that supplies the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 32 | Payload word |
| out_keep | output | 4 | Valid byte lanes |
| out_last | output | 1 | End of transfer |
| out_id | output | 14 | Transfer tag |

## Verification
The bench goes after three classes of corner case:
- Wrap and index handling. A ring that wraps from the last slot to slot 0 would fetch beyond the ring if the mask were dropped. A write index written as the entry count must read back as zero.
- Beat boundaries. Byte counts of 0, 5, 10 and 13 catch an off-by-one in the beat count or the keep mask, which would show as a missing or extra beat. A count exactly at the cap must not raise the clip flag, and a count above it must.
- Chains. A chain left open with no further work published must not emit an end marker and must not hang with the read index short. Both downstream ready and memory ready are throttled throughout, so an index that advanced on the last beat's presentation rather than its acceptance would surface as a read index running ahead of the beats received.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTES_W    = WORD_W / 8;
    localparam int CNT_W      = 16;
    localparam int FLAG_W     = 16;
    localparam int ID_W       = FLAG_W - 2;
    localparam int REG_AW     = 3;
    localparam int DESC_BYTES = 8;

    localparam logic [REG_AW-1:0] RA_BASE = 3'd0;
    localparam logic [REG_AW-1:0] RA_SIZE = 3'd1;
    localparam logic [REG_AW-1:0] RA_WIDX = 3'd2;
    localparam logic [REG_AW-1:0] RA_RIDX = 3'd3;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd4;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd5;

    // Flags half-word of descriptor word 1, bit 0 lowest
    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            swap;
        logic            chain;
    } dflags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DADDR_REQ,
        ST_DADDR_WAIT,
        ST_DCNT_REQ,
        ST_DCNT_WAIT,
        ST_BUF_REQ,
        ST_BUF_WAIT,
        ST_EMIT
    } eng_state_t;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
    import dring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rd_adv,
    input  logic              len_err,
    output logic [31:0]       base_o,
    output logic              active_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic [CNT_W-1:0]  max_len_o,
    output logic              err_o
);

    localparam int SZ_W = IDX_W + 1;

    logic [31:0]      base_q;
    logic [SZ_W-1:0]  size_q;
    logic [SZ_W-1:0]  size_m1;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] wr_q;
    logic [IDX_W-1:0] rd_q;
    logic [CNT_W-1:0] maxl_q;
    logic             err_q;

    logic we_base, we_size, we_widx, we_ctrl, we_stat;

    assign we_base = reg_wen && (reg_addr == RA_BASE);
    assign we_size = reg_wen && (reg_addr == RA_SIZE);
    assign we_widx = reg_wen && (reg_addr == RA_WIDX);
    assign we_ctrl = reg_wen && (reg_addr == RA_CTRL);
    assign we_stat = reg_wen && (reg_addr == RA_STAT);

    assign size_m1 = size_q - 1'b1;
    assign mask    = (size_q == '0) ? '0 : size_m1[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            maxl_q <= '0;
        end else begin
            if (we_base) base_q <= reg_wdata;
            if (we_ctrl) maxl_q <= reg_wdata[CNT_W-1:0];
            if (we_size) begin
                size_q <= reg_wdata[SZ_W-1:0];
                wr_q   <= '0;
                rd_q   <= '0;
            end else begin
                if (we_widx) wr_q <= reg_wdata[IDX_W-1:0] & mask;
                if (rd_adv)  rd_q <= (rd_q + 1'b1) & mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      err_q <= 1'b0;
        else if (len_err)                err_q <= 1'b1;
        else if (we_stat && reg_wdata[0]) err_q <= 1'b0;
    end

    always_comb begin
        case (reg_addr)
            RA_BASE: reg_rdata = base_q;
            RA_SIZE: reg_rdata = 32'(size_q);
            RA_WIDX: reg_rdata = 32'(wr_q);
            RA_RIDX: reg_rdata = 32'(rd_q);
            RA_CTRL: reg_rdata = 32'(maxl_q);
            RA_STAT: reg_rdata = {31'd0, err_q};
            default: reg_rdata = '0;
        endcase
    end

    assign base_o    = base_q;
    assign active_o  = (size_q != '0);
    assign wr_idx_o  = wr_q;
    assign rd_idx_o  = rd_q;
    assign max_len_o = maxl_q;
    assign err_o     = err_q;

endmodule

// File: rtl/dring_fetch_fsm.sv
module dring_fetch_fsm
    import dring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [31:0]       base,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CNT_W-1:0]  max_len,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              emit_valid,
    input  logic              emit_ready,
    output logic [31:0]       word_o,
    output dflags_t           flags_o,
    output logic [CNT_W-1:0]  bytes_o,
    output logic              beat_last,
    output logic              rd_adv,
    output logic              len_err
);

    localparam int PAD_W = 32 - IDX_W - $clog2(DESC_BYTES);

    eng_state_t state_q, state_d;

    logic [31:0]      buf_addr_q;
    logic [31:0]      word_q;
    dflags_t          flags_q;
    logic [CNT_W-1:0] bytes_q;
    logic [CNT_W-1:0] beats_q;

    logic [31:0]      desc_addr;
    logic [CNT_W-1:0] cnt_in;
    logic             clip;
    logic [CNT_W-1:0] eff_len;
    logic [CNT_W:0]   eff_p3;
    logic [CNT_W-1:0] beats_calc;

    assign desc_addr  = base + {{PAD_W{1'b0}}, rd_idx, 3'b000};
    assign cnt_in     = mem_rsp_data[CNT_W-1:0];
    assign clip       = cnt_in > max_len;
    assign eff_len    = clip ? max_len : cnt_in;
    assign eff_p3     = {1'b0, eff_len} + 3'd3;
    assign beats_calc = (eff_len == '0) ? CNT_W'(1) : {1'b0, eff_p3[CNT_W:2]};
    assign beat_last  = (beats_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (active && (rd_idx != wr_idx)) state_d = ST_DADDR_REQ;
            ST_DADDR_REQ:  if (mem_req_ready) state_d = ST_DADDR_WAIT;
            ST_DADDR_WAIT: if (mem_rsp_valid) state_d = ST_DCNT_REQ;
            ST_DCNT_REQ:   if (mem_req_ready) state_d = ST_DCNT_WAIT;
            ST_DCNT_WAIT:  if (mem_rsp_valid) state_d = ST_BUF_REQ;
            ST_BUF_REQ:    if (mem_req_ready) state_d = ST_BUF_WAIT;
            ST_BUF_WAIT:   if (mem_rsp_valid) state_d = ST_EMIT;
            ST_EMIT:       if (emit_ready)    state_d = beat_last ? ST_IDLE : ST_BUF_REQ;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        emit_valid    = 1'b0;
        rd_adv        = 1'b0;
        len_err       = 1'b0;
        unique case (state_q)
            ST_DADDR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_addr;
            end
            ST_DCNT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_addr + 32'd4;
            end
            ST_DCNT_WAIT: len_err = mem_rsp_valid && clip;
            ST_BUF_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = buf_addr_q;
            end
            ST_EMIT: begin
                emit_valid = 1'b1;
                rd_adv     = emit_ready && beat_last;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_addr_q <= '0;
            word_q     <= '0;
            flags_q    <= '0;
            bytes_q    <= '0;
            beats_q    <= '0;
        end else begin
            if (state_q == ST_DADDR_WAIT && mem_rsp_valid)
                buf_addr_q <= mem_rsp_data;
            if (state_q == ST_DCNT_WAIT && mem_rsp_valid) begin
                flags_q <= dflags_t'(mem_rsp_data[31:16]);
                bytes_q <= eff_len;
                beats_q <= beats_calc;
            end
            if (state_q == ST_BUF_WAIT && mem_rsp_valid)
                word_q <= mem_rsp_data;
            if (state_q == ST_EMIT && emit_ready && !beat_last) begin
                buf_addr_q <= buf_addr_q + 32'd4;
                beats_q    <= beats_q - 1'b1;
                bytes_q    <= (bytes_q >= CNT_W'(BYTES_W)) ? bytes_q - CNT_W'(BYTES_W) : '0;
            end
        end
    end

    assign word_o  = word_q;
    assign flags_o = flags_q;
    assign bytes_o = bytes_q;

endmodule

// File: rtl/dring_beat_fmt.sv
module dring_beat_fmt
    import dring_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic               swap_i,
    input  logic [CNT_W-1:0]   bytes_i,
    output logic [WORD_W-1:0]  data_o,
    output logic [BYTES_W-1:0] keep_o
);

    for (genvar g = 0; g < BYTES_W; g++) begin : g_lane
        assign data_o[8*g +: 8] = swap_i ? word_i[8*(BYTES_W-1-g) +: 8]
                                         : word_i[8*g +: 8];
        assign keep_o[g]        = bytes_i > CNT_W'(g);
    end

endmodule

// File: rtl/dring_src_engine.sv
module dring_src_engine
    import dring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic [3:0]        out_keep,
    output logic              out_last,
    output logic [13:0]       out_id
);

    logic [31:0]      base;
    logic             active;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] max_len;
    logic             err_flag;
    logic             rd_adv;
    logic             len_err;
    logic [31:0]      word;
    dflags_t          flags;
    logic [CNT_W-1:0] bytes_left;
    logic             beat_last;

    dring_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rd_adv    (rd_adv),
        .len_err   (len_err),
        .base_o    (base),
        .active_o  (active),
        .wr_idx_o  (wr_idx),
        .rd_idx_o  (rd_idx),
        .max_len_o (max_len),
        .err_o     (err_flag)
    );

    dring_fetch_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .base          (base),
        .rd_idx        (rd_idx),
        .wr_idx        (wr_idx),
        .max_len       (max_len),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .emit_valid    (out_valid),
        .emit_ready    (out_ready),
        .word_o        (word),
        .flags_o       (flags),
        .bytes_o       (bytes_left),
        .beat_last     (beat_last),
        .rd_adv        (rd_adv),
        .len_err       (len_err)
    );

    dring_beat_fmt u_fmt (
        .word_i  (word),
        .swap_i  (flags.swap),
        .bytes_i (bytes_left),
        .data_o  (out_data),
        .keep_o  (out_keep)
    );

    assign out_last = out_valid && beat_last && !flags.chain;
    assign out_id   = flags.id;

endmodule

module dring_src_engine_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [31:0]      mem_req_addr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic [3:0]       out_keep,
    input logic             out_last,
    input logic [IDX_W-1:0] rd_idx,
    input logic             err_flag,
    input logic             size_wr,
    input logic             clr_wr
);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_keep));

    // R7
    ridx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx != $past(rd_idx) |-> $past(out_valid && out_ready) || $past(size_wr));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) && !$past(clr_wr) |-> err_flag);

    // R5
    keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({1'b0, out_keep} + 5'd1));

endmodule

bind dring_src_engine dring_src_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_keep      (out_keep),
    .out_last      (out_last),
    .rd_idx        (rd_idx),
    .err_flag      (err_flag),
    .size_wr       (reg_wen && (reg_addr == dring_pkg::RA_SIZE)),
    .clr_wr        (reg_wen && (reg_addr == dring_pkg::RA_STAT) && reg_wdata[0])
);

// File: tb/tb_dring_src_engine.sv
module tb_dring_src_engine;
    import dring_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RING_BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wen;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        out_valid, out_ready;
    logic [31:0] out_data;
    logic [3:0]  out_keep;
    logic        out_last;
    logic [13:0] out_id;

    dring_src_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_keep(out_keep), .out_last(out_last), .out_id(out_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  keep;
        logic        last;
        logic [13:0] id;
    } beat_t;

    beat_t       exp_q[$];
    string       tag_q[$];
    logic [31:0] mem [0:1023];
    int          errors = 0;
    int          checks = 0;
    int          req_count = 0;
    int          last_count = 0;
    int          cyc = 0;
    int          cur_max = 64;
    bit          pend = 1'b0;
    logic [31:0] pend_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model, ready throttling and output monitor (scoreboard)
    initial begin
        mem_req_ready = 1'b0;
        out_ready     = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_req_ready = (cyc % 5) != 3;
            out_ready     = ((cyc % 7) != 2) && ((cyc % 11) != 4);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[pend_addr[11:2]];
                pend = 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                pend      = 1'b1;
                pend_addr = mem_req_addr;
                req_count++;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected beat", out_data, 32'h0);
                end else begin
                    beat_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data == e.data, t, "beat data", out_data, e.data);
                    chk(out_keep == e.keep, "R5", "beat keep", 32'(out_keep), 32'(e.keep));
                    chk(out_last == e.last, "R6", "beat last", 32'(out_last), 32'(e.last));
                    chk(out_id == e.id, "R12", "beat tag", 32'(out_id), 32'(e.id));
                end
                if (out_last) last_count++;
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: builds descriptor and payload, pushes expected beats
    task automatic post_desc(input int idx, input logic [31:0] bufa, input int nbytes,
                             input bit chain, input bit swap, input int id, input string tag);
        int dw, words, eff, nb;
        dw = int'((RING_BASE + 32'(idx * 8)) >> 2);
        mem[dw]     = bufa;
        mem[dw + 1] = {14'(id), swap, chain, 16'(nbytes)};
        words = (nbytes + 3) / 4;
        if (words == 0) words = 1;
        for (int k = 0; k < words; k++)
            mem[int'(bufa >> 2) + k] = {bufa[15:0] + 16'(k), 16'hC3A5 ^ 16'(k * 3)};
        eff = (nbytes > cur_max) ? cur_max : nbytes;
        nb  = (eff == 0) ? 1 : (eff + 3) / 4;
        for (int k = 0; k < nb; k++) begin
            beat_t b;
            int rem;
            logic [31:0] w;
            w = mem[int'(bufa >> 2) + k];
            if (swap) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
            rem = eff - 4 * k;
            b.data = w;
            b.keep = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
            b.last = (k == nb - 1) && !chain;
            b.id   = 14'(id);
            exp_q.push_back(b);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain(input logic [31:0] exp_ridx);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            reg_read(RA_RIDX, v);
            n++;
        end while ((exp_q.size() != 0 || v != exp_ridx) && n < 3000);
        chk(v == exp_ridx, "R7", "read index after drain", v, exp_ridx);
        chk(exp_q.size() == 0, "R6", "beats still expected", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lc, rc;
        rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'h0);
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), v);
            chk(v == 32'h0, "R1", "register after reset", v, 32'h0);
        end

        // R2 configuration and readback
        reg_write(RA_BASE, RING_BASE);
        reg_write(RA_SIZE, 32'd8);
        reg_write(RA_CTRL, 32'(cur_max));
        reg_read(RA_BASE, v); chk(v == RING_BASE, "R2", "base readback", v, RING_BASE);
        reg_read(RA_SIZE, v); chk(v == 32'd8, "R2", "size readback", v, 32'd8);
        reg_read(RA_CTRL, v); chk(v == 32'd64, "R2", "cap readback", v, 32'd64);
        reg_write(RA_WIDX, 32'd8);
        reg_read(RA_WIDX, v); chk(v == 32'd0, "R2", "write index masked", v, 32'd0);
        reg_write(RA_RIDX, 32'd5);
        reg_read(RA_RIDX, v); chk(v == 32'd0, "R2", "read index read-only", v, 32'd0);
        repeat (10) @(negedge clk);
        chk(req_count == 0, "R3", "requests on empty ring", 32'(req_count), 32'h0);

        // R4 R5 single descriptor, 10 bytes
        post_desc(0, 32'h400, 10, 1'b0, 1'b0, 5, "R4");
        reg_write(RA_WIDX, 32'd1);
        drain(32'd1);

        // R9 reverse, R12 tag, 13-byte tail
        post_desc(1, 32'h480, 8, 1'b0, 1'b1, 'h21, "R9");
        post_desc(2, 32'h500, 13, 1'b0, 1'b0, 'h3FFF, "R5");
        reg_write(RA_WIDX, 32'd3);
        drain(32'd3);

        // R6 chain of three descriptors
        lc = last_count;
        post_desc(3, 32'h600, 6, 1'b1, 1'b0, 7, "R6");
        post_desc(4, 32'h640, 4, 1'b1, 1'b1, 7, "R9");
        post_desc(5, 32'h680, 5, 1'b0, 1'b0, 7, "R6");
        reg_write(RA_WIDX, 32'd6);
        drain(32'd6);
        chk(last_count == lc + 1, "R6", "one end marker per chain", 32'(last_count), 32'(lc + 1));

        // R11 chain left open
        lc = last_count;
        post_desc(6, 32'h700, 4, 1'b1, 1'b0, 9, "R11");
        reg_write(RA_WIDX, 32'd7);
        drain(32'd7);
        repeat (40) @(negedge clk);
        chk(last_count == lc, "R11", "no end marker while open", 32'(last_count), 32'(lc));
        chk(out_valid == 1'b0, "R11", "no beat while waiting", 32'(out_valid), 32'h0);
        // R5 zero-length closer, R7 wrap to slot 0
        post_desc(7, 32'h740, 0, 1'b0, 1'b0, 9, "R5");
        reg_write(RA_WIDX, 32'd8);
        drain(32'd0);
        chk(last_count == lc + 1, "R11", "chain closed once", 32'(last_count), 32'(lc + 1));

        // R8 cap boundary and clipping
        cur_max = 12;
        reg_write(RA_CTRL, 32'd12);
        post_desc(0, 32'h800, 12, 1'b0, 1'b0, 3, "R8");
        reg_write(RA_WIDX, 32'd1);
        drain(32'd1);
        reg_read(RA_STAT, v); chk(v == 32'd0, "R8", "no flag at cap", v, 32'd0);
        post_desc(1, 32'h840, 20, 1'b0, 1'b0, 4, "R8");
        reg_write(RA_WIDX, 32'd2);
        drain(32'd2);
        reg_read(RA_STAT, v); chk(v == 32'd1, "R8", "flag after clip", v, 32'd1);
        repeat (5) @(negedge clk);
        reg_read(RA_STAT, v); chk(v == 32'd1, "R8", "flag sticky", v, 32'd1);
        reg_write(RA_STAT, 32'd1);
        reg_read(RA_STAT, v); chk(v == 32'd0, "R8", "flag cleared", v, 32'd0);
        cur_max = 64;
        reg_write(RA_CTRL, 32'd64);

        // R3 disabled ring
        reg_write(RA_SIZE, 32'd0);
        reg_read(RA_WIDX, v); chk(v == 32'd0, "R2", "write index cleared", v, 32'd0);
        reg_read(RA_RIDX, v); chk(v == 32'd0, "R2", "read index cleared", v, 32'd0);
        rc = req_count;
        reg_write(RA_WIDX, 32'd3);
        repeat (30) @(negedge clk);
        chk(req_count == rc, "R3", "no requests when disabled", 32'(req_count), 32'(rc));
        reg_read(RA_RIDX, v); chk(v == 32'd0, "R3", "read index idle", v, 32'd0);

        // R7 restart after re-enable
        reg_write(RA_SIZE, 32'd8);
        post_desc(0, 32'h900, 4, 1'b0, 1'b0, 2, "R7");
        reg_write(RA_WIDX, 32'd1);
        drain(32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule